// File: doc/BRIEF.md
# Three-Wire Serial Memory Command Front End

This block is the serial front end of a 64-word by 16-bit memory slave reached over a three-wire serial bus: chip select, serial clock and serial data in, plus a serial data out with its own output enable so the pad can float. It oversamples all three input pins on a fast system clock, finds the start bit, and shifts in the opcode, the address and any data. From these it decodes seven commands. It keeps the write-enable latch.

Reads are served from a synchronous memory port: a dummy zero goes out first, then whole words, most significant bit first. The address moves to the next word for as long as chip select stays high. Writes and erases are not carried out here. They leave as program requests on a valid/ready stream to a separate program-cycle controller.

That stream has these rules. A request is offered with `prog_valid_o` and stays in place, unchanged, until a cycle in which `prog_ready_i` is high. Requests are not withdrawn when chip select falls. If a new command finishes while the slot is still full and not being emptied in that cycle, the new request is dropped. The read port has no back-pressure. `rd_data_i` must hold the addressed word in the cycle after the one in which `rd_en_o` and `rd_addr_o` were presented.

Top module: `mw_eeprom_front`

## Requirements
- R1: After chip select rises, zeros sampled on serial clock rising edges are ignored. The first one sampled is the start bit.
- R2: Serial data is sampled on serial clock rising edges, most significant bit first. Opcode 01 followed by 6 address bits and 16 data bits produces a program request of kind 0 (word write) carrying that address and data.
- R3: Opcode 11 followed by 6 address bits produces a program request of kind 1 (word erase) carrying that address and data 16'hFFFF.
- R4: Under opcode 00 the top two address bits select the command and the low four bits are ignored. 11 sets the write-enable latch and 00 clears it. 01 takes 16 data bits and requests kind 2 (write all) with address 0. 10 requests kind 3 (erase all) with address 0 and data 16'hFFFF.
- R5: For opcode 10, DO is enabled and drives 0 after the rising edge that samples the last address bit. D15 down to D0 of the addressed word then follow, one bit per subsequent rising edge.
- R6: While chip select stays high, the bit after D0 is D15 of the next word, with no gap. The address after word 63 is word 0.
- R7: While chip select is low, DO is not enabled, and a command that is not yet complete is abandoned without effect.
- R8: After reset the write-enable latch is clear. Only R4's enable command sets it, and only R4's disable command or reset clears it. Reads work whatever its state.
- R9: While the latch is clear, write, erase, write-all and erase-all are decoded but produce no program request.
- R10: Serial clock edges after a non-read command completes are ignored until chip select falls: there is no further request and DO stays disabled.
- R11: While `prog_valid_o` is high and `prog_ready_i` is low, the request and its kind, address and data stay unchanged. A request that completes while the slot is occupied is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset (stands in for power-on reset) |
| cs_i | input | 1 | Chip select pin, asynchronous |
| sk_i | input | 1 | Serial clock pin, asynchronous |
| di_i | input | 1 | Serial data in pin, asynchronous |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Output enable for serial data out; low means high-Z |
| rd_en_o | output | 1 | Read strobe to the memory array |
| rd_addr_o | output | 6 | Word address for the read strobe |
| rd_data_i | input | 16 | Word returned one cycle after the read strobe |
| prog_valid_o | output | 1 | Program request offered |
| prog_ready_i | input | 1 | Program controller accepts the request |
| prog_kind_o | output | 2 | 0 write, 1 erase, 2 write all, 3 erase all |
| prog_addr_o | output | 6 | Word address of the request |
| prog_data_o | output | 16 | Data to program (all ones for erases) |

## Verification
Some properties are checked on every cycle: DO floats in the cycle after chip select is seen low; the first bit enabled on DO is always the zero dummy; no program request appears unless the latch was set in the cycle before; a stalled request holds its payload; and the read strobe is always a single-cycle pulse. What only the scenarios can show is whether decoding is correct: that each opcode and extended code maps to the right kind, address and data; that leading zeros and stray clocks after a command are ignored; and that streamed words come out in order and wrap past word 63. The scenarios also show that a command broken off by chip select leaves nothing behind, and that a request completing while the slot is full is dropped.

// File: rtl/mwf_pkg.sv
package mwf_pkg;

  typedef enum logic [1:0] {
    PK_WRITE = 2'd0,
    PK_ERASE = 2'd1,
    PK_WRAL  = 2'd2,
    PK_ERAL  = 2'd3
  } prog_kind_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HDR,
    SQ_DATA,
    SQ_READ,
    SQ_DONE
  } seq_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_LOCK   = 2'b00;
  localparam logic [1:0] EXT_FILL   = 2'b01;
  localparam logic [1:0] EXT_WIPE   = 2'b10;
  localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/mwf_pin_sync.sv
module mwf_pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= pin_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign pin_o = stage_q[STAGES-1];

endmodule

// File: rtl/mwf_cmd_seq.sv
module mwf_cmd_seq
  import mwf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sk_rise,
  input  logic              di_i,
  output logic              rd_go,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              req_go,
  output prog_kind_e        req_kind,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              wen_q
);

  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2(DATA_W > HDR_W ? DATA_W : HDR_W);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [HDR_W-1:0]   hdr_q;
  logic [DATA_W-1:0]  dat_q;
  prog_kind_e         pend_kind_q;
  logic [ADDR_W-1:0]  pend_addr_q;

  logic [HDR_W-1:0]  hdr_next;
  logic [DATA_W-1:0] dat_next;
  logic [1:0]        op_w;
  logic [ADDR_W-1:0] addr_w;
  logic [1:0]        ext_w;

  always_comb begin
    hdr_next = {hdr_q[HDR_W-2:0], di_i};
    dat_next = {dat_q[DATA_W-2:0], di_i};
    op_w     = hdr_next[HDR_W-1:HDR_W-2];
    addr_w   = hdr_next[ADDR_W-1:0];
    ext_w    = addr_w[ADDR_W-1:ADDR_W-2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      cnt_q       <= '0;
      hdr_q       <= '0;
      dat_q       <= '0;
      pend_kind_q <= PK_WRITE;
      pend_addr_q <= '0;
      rd_go       <= 1'b0;
      rd_addr     <= '0;
      req_go      <= 1'b0;
      req_kind    <= PK_WRITE;
      req_addr    <= '0;
      req_data    <= '0;
      wen_q       <= 1'b0;
    end else if (!cs_act) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      rd_go   <= 1'b0;
      req_go  <= 1'b0;
    end else begin
      rd_go  <= 1'b0;
      req_go <= 1'b0;
      if (sk_rise) begin
        unique case (state_q)
          SQ_IDLE: begin
            if (di_i) begin
              state_q <= SQ_HDR;
              cnt_q   <= '0;
            end
          end
          SQ_HDR: begin
            hdr_q <= hdr_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(HDR_W - 1)) begin
              cnt_q <= '0;
              unique case (op_w)
                OP_READ: begin
                  rd_go   <= 1'b1;
                  rd_addr <= addr_w;
                  state_q <= SQ_READ;
                end
                OP_WRITE: begin
                  pend_kind_q <= PK_WRITE;
                  pend_addr_q <= addr_w;
                  state_q     <= SQ_DATA;
                end
                OP_ERASE: begin
                  req_go   <= wen_q;
                  req_kind <= PK_ERASE;
                  req_addr <= addr_w;
                  req_data <= '1;
                  state_q  <= SQ_DONE;
                end
                default: begin
                  unique case (ext_w)
                    EXT_UNLOCK: begin
                      wen_q   <= 1'b1;
                      state_q <= SQ_DONE;
                    end
                    EXT_LOCK: begin
                      wen_q   <= 1'b0;
                      state_q <= SQ_DONE;
                    end
                    EXT_FILL: begin
                      pend_kind_q <= PK_WRAL;
                      pend_addr_q <= '0;
                      state_q     <= SQ_DATA;
                    end
                    default: begin
                      req_go   <= wen_q;
                      req_kind <= PK_ERAL;
                      req_addr <= '0;
                      req_data <= '1;
                      state_q  <= SQ_DONE;
                    end
                  endcase
                end
              endcase
            end
          end
          SQ_DATA: begin
            dat_q <= dat_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              req_go   <= wen_q;
              req_kind <= pend_kind_q;
              req_addr <= pend_addr_q;
              req_data <= dat_next;
              state_q  <= SQ_DONE;
            end
          end
          default: state_q <= state_q;
        endcase
      end
    end
  end

endmodule

// File: rtl/mwf_read_ser.sv
module mwf_read_ser #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sk_rise,
  input  logic              rd_go,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              do_o,
  output logic              do_oe_o
);

  localparam int BIT_W = $clog2(DATA_W);

  logic              active_q;
  logic              load_q;
  logic [DATA_W-1:0] word_q;
  logic [BIT_W-1:0]  bidx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      load_q    <= 1'b0;
      word_q    <= '0;
      bidx_q    <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
      do_o      <= 1'b0;
      do_oe_o   <= 1'b0;
    end else if (!cs_act) begin
      active_q <= 1'b0;
      load_q   <= 1'b0;
      rd_en_o  <= 1'b0;
      do_o     <= 1'b0;
      do_oe_o  <= 1'b0;
    end else begin
      rd_en_o <= 1'b0;
      load_q  <= rd_en_o;
      if (load_q) word_q <= rd_data_i;
      if (rd_go) begin
        active_q  <= 1'b1;
        rd_addr_o <= start_addr;
        rd_en_o   <= 1'b1;
        bidx_q    <= '0;
        do_o      <= 1'b0;
        do_oe_o   <= 1'b1;
      end else if (active_q && sk_rise) begin
        do_o   <= word_q[DATA_W-1];
        word_q <= {word_q[DATA_W-2:0], 1'b0};
        bidx_q <= bidx_q + 1'b1;
        if (bidx_q == BIT_W'(DATA_W - 1)) begin
          bidx_q    <= '0;
          rd_addr_o <= rd_addr_o + 1'b1;
          rd_en_o   <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/mwf_req_slot.sv
module mwf_req_slot
  import mwf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  prog_kind_e        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [1:0]        kind_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic slot_free;
  assign slot_free = !valid_o || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      kind_o  <= '0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (go_i && slot_free) begin
        valid_o <= 1'b1;
        kind_o  <= kind_i;
        addr_o  <= addr_i;
        data_o  <= data_i;
      end
    end
  end

endmodule

// File: rtl/mw_eeprom_front.sv
module mw_eeprom_front
  import mwf_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              prog_valid_o,
  input  logic              prog_ready_i,
  output logic [1:0]        prog_kind_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o
);

  logic [2:0]        pins_s;
  logic              cs_s, sk_s, di_s;
  logic              sk_prev_q, sk_rise;
  logic              rd_go;
  logic [ADDR_W-1:0] rd_start;
  logic              req_go;
  prog_kind_e        req_kind;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic              wen_q;

  mwf_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i ({cs_i, sk_i, di_i}),
    .pin_o (pins_s)
  );

  assign cs_s = pins_s[2];
  assign sk_s = pins_s[1];
  assign di_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_prev_q <= 1'b0;
    else        sk_prev_q <= sk_s;
  end
  assign sk_rise = sk_s && !sk_prev_q;

  mwf_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_act   (cs_s),
    .sk_rise  (sk_rise),
    .di_i     (di_s),
    .rd_go    (rd_go),
    .rd_addr  (rd_start),
    .req_go   (req_go),
    .req_kind (req_kind),
    .req_addr (req_addr),
    .req_data (req_data),
    .wen_q    (wen_q)
  );

  mwf_read_ser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_s),
    .sk_rise    (sk_rise),
    .rd_go      (rd_go),
    .start_addr (rd_start),
    .rd_data_i  (rd_data_i),
    .rd_en_o    (rd_en_o),
    .rd_addr_o  (rd_addr_o),
    .do_o       (do_o),
    .do_oe_o    (do_oe_o)
  );

  mwf_req_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (req_go),
    .kind_i  (req_kind),
    .addr_i  (req_addr),
    .data_i  (req_data),
    .valid_o (prog_valid_o),
    .ready_i (prog_ready_i),
    .kind_o  (prog_kind_o),
    .addr_o  (prog_addr_o),
    .data_o  (prog_data_o)
  );

endmodule

// File: rtl/mwf_front_chk.sv
module mwf_front_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_act,
  input logic              wen,
  input logic              do_o,
  input logic              do_oe_o,
  input logic              rd_en_o,
  input logic              prog_valid_o,
  input logic              prog_ready_i,
  input logic [1:0]        prog_kind_o,
  input logic [ADDR_W-1:0] prog_addr_o,
  input logic [DATA_W-1:0] prog_data_o
);

  AST_HIZ_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !do_oe_o); // R7

  AST_FIRST_BIT_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe_o) |-> !do_o); // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_valid_o && !prog_ready_i) |=> (prog_valid_o && $stable(prog_kind_o)
      && $stable(prog_addr_o) && $stable(prog_data_o))); // R11

  AST_REQ_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_valid_o) |-> $past(wen)); // R9

  AST_LATCH_CLEAR_AFTER_RESET: assert property (@(posedge clk)
    !rst_n |=> !wen); // R8

  AST_READ_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o); // R6

endmodule

bind mw_eeprom_front mwf_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_act       (cs_s),
  .wen          (wen_q),
  .do_o         (do_o),
  .do_oe_o      (do_oe_o),
  .rd_en_o      (rd_en_o),
  .prog_valid_o (prog_valid_o),
  .prog_ready_i (prog_ready_i),
  .prog_kind_o  (prog_kind_o),
  .prog_addr_o  (prog_addr_o),
  .prog_data_o  (prog_data_o)
);

// File: tb/mw_eeprom_front_test.sv
`timescale 1ns/1ps
module mw_eeprom_front_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic        do_w, do_oe;
  logic        rd_en;
  logic [5:0]  rd_addr;
  logic [15:0] rd_data = '0;
  logic        prog_valid;
  logic        prog_ready = 1'b1;
  logic [1:0]  prog_kind;
  logic [5:0]  prog_addr;
  logic [15:0] prog_data;

  int n_chk = 0, n_err = 0, n_acc = 0;
  bit done = 0;
  logic last_do, last_oe;
  logic [23:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  mw_eeprom_front uut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_w), .do_oe_o(do_oe), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .prog_valid_o(prog_valid), .prog_ready_i(prog_ready),
    .prog_kind_o(prog_kind), .prog_addr_o(prog_addr), .prog_data_o(prog_data)
  );

  function automatic logic [15:0] pattern(input logic [5:0] a);
    return {2'b10, a, ~a, 2'b01};
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= pattern(rd_addr);

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && prog_valid && prog_ready) begin
      n_acc++;
      if (exp_q.size() == 0) chk("R9", "unexpected request", {8'h0, prog_kind, prog_addr, prog_data}, 32'h0);
      else begin
        string t;
        logic [23:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "request kind/addr/data", {8'h0, prog_kind, prog_addr, prog_data}, {8'h0, e});
      end
    end
  end

  task automatic expect_req(input logic [1:0] k, input logic [5:0] a, input logic [15:0] d, input string tag);
    exp_q.push_back({k, a, d});
    tag_q.push_back(tag);
  endtask

  task automatic sk_cycle(input logic b);
    di = b;
    repeat (4) @(negedge clk);
    sk = 1'b1;
    repeat (8) @(negedge clk);
    last_do = do_w;
    last_oe = do_oe;
    sk = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk);
    sk = 1'b0; di = 1'b0; cs = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_off();
    di = 1'b0; cs = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic header(input logic [1:0] op, input logic [5:0] a);
    sk_cycle(1'b1);
    sk_cycle(op[1]);
    sk_cycle(op[0]);
    for (int i = 5; i >= 0; i--) sk_cycle(a[i]);
  endtask

  task automatic data16(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) sk_cycle(d[i]);
  endtask

  task automatic settle(input string tag, input int acc_before, input int acc_delta);
    repeat (30) @(negedge clk);
    chk(tag, "accepted request count", n_acc - acc_before, acc_delta);
    chk(tag, "scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic read_words(input logic [5:0] a, input int n, input string tag);
    logic [15:0] w;
    cs_on();
    header(2'b10, a);
    chk("R5", "dummy bit {oe,do}", {last_oe, last_do}, 2'b10);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int i = 0; i < 16; i++) begin
        sk_cycle(1'b0);
        w = {w[14:0], last_do};
        if (!last_oe) chk(tag, "DO enabled during word", last_oe, 1'b1);
      end
      chk(tag, "streamed word", w, pattern(a + 6'(k)));
    end
    cs_off();
    chk("R7", "DO disabled after deselect", do_oe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int acc0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7", "reset DO enable", do_oe, 1'b0);
    chk("R11", "reset request valid", prog_valid, 1'b0);

    // R9 / R8: latch clear after reset, write produces nothing
    acc0 = n_acc;
    cs_on(); header(2'b01, 6'd3); data16(16'h1111); cs_off();
    settle("R9", acc0, 0);

    // R4 unlock with don't-care low bits, then R2 write
    cs_on(); header(2'b00, 6'b110101); cs_off();
    acc0 = n_acc;
    expect_req(2'd0, 6'd5, 16'hA5A5, "R2");
    cs_on(); header(2'b01, 6'd5); data16(16'hA5A5); cs_off();
    settle("R2", acc0, 1);

    // R1 leading zeros before the start bit
    acc0 = n_acc;
    expect_req(2'd0, 6'd6, 16'h0F0F, "R1");
    cs_on(); sk_cycle(1'b0); sk_cycle(1'b0); sk_cycle(1'b0);
    header(2'b01, 6'd6); data16(16'h0F0F); cs_off();
    settle("R1", acc0, 1);

    // R3 erase
    acc0 = n_acc;
    expect_req(2'd1, 6'd7, 16'hFFFF, "R3");
    cs_on(); header(2'b11, 6'd7); cs_off();
    settle("R3", acc0, 1);

    // R4 write all and erase all
    acc0 = n_acc;
    expect_req(2'd2, 6'd0, 16'h1234, "R4");
    cs_on(); header(2'b00, 6'b011010); data16(16'h1234); cs_off();
    expect_req(2'd3, 6'd0, 16'hFFFF, "R4");
    cs_on(); header(2'b00, 6'b100111); cs_off();
    settle("R4", acc0, 2);

    // R5 / R6 reads with streaming and wrap
    read_words(6'd5, 2, "R5");
    read_words(6'd63, 2, "R6");

    // R7 abandoned write and abandoned read
    acc0 = n_acc;
    cs_on(); header(2'b01, 6'd9); for (int i = 0; i < 8; i++) sk_cycle(1'b1); cs_off();
    settle("R7", acc0, 0);
    cs_on(); header(2'b10, 6'd2); for (int i = 0; i < 5; i++) sk_cycle(1'b0);
    chk("R7", "DO enabled mid-read", do_oe, 1'b1);
    cs_off();
    chk("R7", "DO disabled after abort", do_oe, 1'b0);

    // R10 stray clocks after a finished erase
    acc0 = n_acc;
    expect_req(2'd1, 6'd9, 16'hFFFF, "R10");
    cs_on(); header(2'b11, 6'd9);
    for (int i = 0; i < 12; i++) begin
      sk_cycle(i[0]);
      if (last_oe) chk("R10", "DO stays disabled", last_oe, 1'b0);
    end
    chk("R10", "DO disabled after stray clocks", last_oe, 1'b0);
    cs_off();
    settle("R10", acc0, 1);

    // R11 back-pressure: hold, drop second, then accept
    @(posedge clk); #1 prog_ready = 1'b0;
    acc0 = n_acc;
    expect_req(2'd0, 6'd12, 16'hC3C3, "R11");
    cs_on(); header(2'b01, 6'd12); data16(16'hC3C3); cs_off();
    repeat (20) @(negedge clk);
    chk("R11", "valid held while stalled", prog_valid, 1'b1);
    chk("R11", "payload held while stalled", {prog_kind, prog_addr, prog_data}, {2'd0, 6'd12, 16'hC3C3});
    cs_on(); header(2'b11, 6'd13); cs_off();
    chk("R11", "payload kept after second command", {prog_kind, prog_addr, prog_data}, {2'd0, 6'd12, 16'hC3C3});
    @(posedge clk); #1 prog_ready = 1'b1;
    settle("R11", acc0, 1);

    // R8 lock again; erase ignored, read still works
    cs_on(); header(2'b00, 6'b001010); cs_off();
    acc0 = n_acc;
    cs_on(); header(2'b11, 6'd2); cs_off();
    settle("R8", acc0, 0);
    read_words(6'd0, 1, "R8");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule